// File: doc/BRIEF.md
# Base-Limit Address Relocation Unit

This block sits between a processor's logical address bus and the physical memory bus. It holds two registers for the process that is running: a base, which is the lowest physical byte the process owns, and a limit, which is the length of its region in bytes. On every user-mode read or write strobe it compares the logical address with the limit. If the address is below the limit, it forwards the strobe with the address relocated by the base. If not, it suppresses the strobe and raises a bus-error exception in the same cycle.

Privileged software loads the base and the limit through a small write port before it schedules a process. Supervisor-mode accesses pass straight through: they are not relocated and they are never checked. A user-mode attempt to write either register has no effect and is recorded as a fault. A registered fault flag collects every violation and stays set until software pulses a clear input.

Top module: `reloc_unit`

## Requirements
- R1: After reset the base and the limit are both 0 and `fault` is 0. Every user-mode access after reset is therefore out of range.
- R2: A user-mode access whose address is below the limit drives `mem_addr = cpu_addr + base`, taken modulo 2^AW. The strobe is forwarded in the same cycle and `bus_err` stays 0.
- R3: A user-mode access whose address is greater than or equal to the limit, compared as unsigned numbers, raises `bus_err` in the same cycle. It forces `mem_rd` and `mem_wr` to 0 and `mem_addr` to 0.
- R4: The range check applies to reads and writes alike, and each forwarded strobe keeps its own kind. A cycle with no strobe never raises `bus_err` and forwards no strobe.
- R5: A supervisor-mode access (`cpu_super` = 1) drives `mem_addr = cpu_addr`, forwards its strobe and never raises `bus_err`, whatever the base and the limit hold.
- R6: A supervisor-mode register write (`cfg_we` = 1, `cpu_super` = 1) loads `cfg_data` into the base when `cfg_sel` = 0 and into the limit when `cfg_sel` = 1. The new value governs accesses from the next cycle on.
- R7: A register write made in user mode leaves both registers unchanged and sets `fault` at the next clock edge.
- R8: `fault` becomes 1 at the clock edge after a cycle with `bus_err` = 1. It then holds until a cycle with `fault_clr` = 1 and no new violation. When a violation and a clear fall in the same cycle, the violation wins.
- R9: The relocated address wraps modulo 2^AW when the sum of address and base overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_super | input | 1 | 1 = supervisor-mode cycle, 0 = user-mode cycle |
| cpu_rd | input | 1 | Read strobe from the processor |
| cpu_wr | input | 1 | Write strobe from the processor |
| cpu_addr | input | AW | Logical address |
| cfg_we | input | 1 | Register write request |
| cfg_sel | input | 1 | Register select: 0 base, 1 limit |
| cfg_data | input | AW | Value to load |
| fault_clr | input | 1 | Clears the fault flag |
| mem_rd | output | 1 | Read strobe to memory |
| mem_wr | output | 1 | Write strobe to memory |
| mem_addr | output | AW | Physical address |
| bus_err | output | 1 | Exception for the current access |
| fault | output | 1 | Registered sticky fault flag |

## Verification
The bench uses an 8-bit address width and sweeps every logical address in user mode under several base and limit pairs. It alternates reads and writes. One pair has a zero limit, one has a full-range limit, one sets the limit to exactly half the range, and one has a base large enough that the sum overflows. Together these separate the off-by-one edge of the unsigned compare from a signed or strict-greater compare, and catch a truncated or saturating adder. A second sweep runs in supervisor mode with a restrictive limit, which shows that the bypass skips both the check and the relocation. Directed cycles then cover user-mode register writes, a cycle with no strobe, and a violation and a clear that fall in the same cycle.

// File: rtl/reloc_pkg.sv
// reloc_pkg: shared definitions for the relocation unit.
// Assumes: the register select is a single bit coming from the processor side.
package reloc_pkg;

    // Which relocation register a configuration write targets.
    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_LIMIT = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/reloc_regs.sv
// reloc_regs: holds the base and limit registers of the running process.
// Only supervisor-mode writes load them. A user-mode write is dropped and
// reported through user_wr_viol so that the fault logic can record it.
// Assumes: cfg_sel is stable whenever cfg_we is high.
module reloc_regs
    import reloc_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_super,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_data,
    output logic [AW-1:0] base_q,
    output logic [AW-1:0] limit_q,
    output logic          user_wr_viol
);

    localparam logic [AW-1:0] ZERO = '0;

    logic wr_ok;

    // Decode a permitted write and a forbidden one.
    always_comb begin
        wr_ok        = cfg_we && cfg_super;
        user_wr_viol = cfg_we && !cfg_super;
    end

    // Load the selected register on a permitted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= ZERO;
            limit_q <= ZERO;
        end else if (wr_ok) begin
            if (reg_sel_e'(cfg_sel) == SEL_BASE) base_q  <= cfg_data;
            else                                 limit_q <= cfg_data;
        end
    end

    // R7: a user-mode write leaves both registers untouched.
    a_r7_user_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_super) |=> ($stable(base_q) && $stable(limit_q)));

    // R6: a supervisor write to the limit lands at the next edge.
    a_r6_limit_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_super && cfg_sel) |=> (limit_q == $past(cfg_data)));

endmodule

// File: rtl/reloc_xlate.sv
// reloc_xlate: combinational check and relocation of one processor access.
// A user access at or above the limit is blocked: both strobes are dropped,
// the address is forced to zero and bus_err is raised. A legal user access
// is relocated by the base, wrapping modulo 2^AW. A supervisor access
// bypasses both the check and the relocation.
// Assumes: cpu_rd and cpu_wr come from the same cycle as cpu_addr.
module reloc_xlate #(
    parameter int AW = 32
) (
    input  logic          cpu_super,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic [AW-1:0] cpu_addr,
    input  logic [AW-1:0] base_q,
    input  logic [AW-1:0] limit_q,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic          bus_err
);

    logic          strobe;
    logic          out_of_range;
    logic [AW-1:0] reloc_addr;

    // Unsigned range compare and wrapping relocation.
    always_comb begin
        strobe       = cpu_rd || cpu_wr;
        out_of_range = (cpu_addr >= limit_q);
        reloc_addr   = cpu_addr + base_q;
    end

    // Select between bypass, relocation and blocking.
    always_comb begin
        bus_err  = 1'b0;
        mem_rd   = cpu_rd;
        mem_wr   = cpu_wr;
        mem_addr = cpu_addr;
        if (!cpu_super) begin
            if (strobe && out_of_range) begin
                bus_err  = 1'b1;
                mem_rd   = 1'b0;
                mem_wr   = 1'b0;
                mem_addr = '0;
            end else begin
                mem_addr = reloc_addr;
            end
        end
    end

endmodule

// File: rtl/reloc_fault.sv
// reloc_fault: sticky fault flag. It is set by an access violation or a
// forbidden register write and cleared by a clear pulse. A new violation
// wins over a clear in the same cycle.
// Assumes: fault_clr is a single-cycle pulse from privileged software.
module reloc_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_viol,
    input  logic wr_viol,
    input  logic fault_clr,
    output logic fault
);

    logic any_viol;

    // Merge the two sources of a fault.
    always_comb any_viol = acc_viol || wr_viol;

    // Hold the flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         fault <= 1'b0;
        else if (any_viol)  fault <= 1'b1;
        else if (fault_clr) fault <= 1'b0;
    end

    // R8: any violation sets the flag at the next edge.
    a_r8_fault_sets: assert property (@(posedge clk) disable iff (!rst_n)
        any_viol |=> fault);

    // R8: without a clear, the flag holds.
    a_r8_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !fault_clr) |=> fault);

endmodule

// File: rtl/reloc_unit.sv
// reloc_unit: base-limit relocation and protection between the processor's
// logical address bus and the physical memory bus.
// Assumes: registers are programmed in supervisor mode before user code runs;
// exception handling lies outside this block.
module reloc_unit #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_super,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_data,
    input  logic          fault_clr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic          bus_err,
    output logic          fault
);

    logic [AW-1:0] base_q;
    logic [AW-1:0] limit_q;
    logic          user_wr_viol;

    // Register file for base and limit.
    reloc_regs #(.AW(AW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_super    (cpu_super),
        .cfg_sel      (cfg_sel),
        .cfg_data     (cfg_data),
        .base_q       (base_q),
        .limit_q      (limit_q),
        .user_wr_viol (user_wr_viol)
    );

    // Range check and relocation datapath.
    reloc_xlate #(.AW(AW)) u_xlate (
        .cpu_super (cpu_super),
        .cpu_rd    (cpu_rd),
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .base_q    (base_q),
        .limit_q   (limit_q),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .bus_err   (bus_err)
    );

    // Sticky fault record.
    reloc_fault u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_viol  (bus_err),
        .wr_viol   (user_wr_viol),
        .fault_clr (fault_clr),
        .fault     (fault)
    );

    // R3: a blocked access never reaches memory.
    a_r3_err_blocks_mem: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (!mem_rd && !mem_wr));

    // R5: a supervisor access never faults and is not relocated.
    a_r5_super_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_super |-> (!bus_err && mem_addr == cpu_addr));

    // R4: with no strobe there is no exception and no memory cycle.
    a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd && !cpu_wr) |-> (!bus_err && !mem_rd && !mem_wr));

endmodule

// File: tb/tb_reloc_unit.sv
// tb_reloc_unit: exhaustive address sweeps on an 8-bit configuration.
module tb_reloc_unit;

    localparam int AW = 8;
    localparam int SPAN = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpu_super, cpu_rd, cpu_wr;
    logic [AW-1:0] cpu_addr;
    logic          cfg_we, cfg_sel;
    logic [AW-1:0] cfg_data;
    logic          fault_clr;
    logic          mem_rd, mem_wr, bus_err, fault;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    reloc_unit #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_super(cpu_super), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_data(cfg_data), .fault_clr(fault_clr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .bus_err(bus_err), .fault(fault)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        cpu_rd = 0; cpu_wr = 0; cfg_we = 0; fault_clr = 0;
    endtask

    // Supervisor register write; it takes effect at the next edge.
    task automatic prog(input bit sel, input int val);
        @(negedge clk);
        idle(); cpu_super = 1; cfg_we = 1; cfg_sel = sel; cfg_data = AW'(val);
        @(negedge clk);
        idle();
    endtask

    task automatic clr_fault();
        @(negedge clk);
        idle(); fault_clr = 1;
        @(negedge clk);
        idle();
    endtask

    // User-mode sweep over every address; expected values are computed here.
    task automatic user_sweep(input string req, input int base, input int lim);
        for (int a = 0; a < SPAN; a++) begin
            @(negedge clk);
            idle(); cpu_super = 0; cpu_addr = AW'(a);
            if (a % 2 == 0) cpu_rd = 1; else cpu_wr = 1;
            #1;
            if (a < lim) begin
                chk({req, " R2 addr"}, int'(mem_addr), (a + base) % SPAN);
                chk({req, " R4 kind"}, {mem_rd, mem_wr}, (a % 2 == 0) ? 2 : 1);
                chk({req, " R2 no err"}, int'(bus_err), 0);
            end else begin
                chk({req, " R3 err"}, int'(bus_err), 1);
                chk({req, " R3 blocked"}, {mem_rd, mem_wr}, 0);
                chk({req, " R3 addr0"}, int'(mem_addr), 0);
            end
        end
        @(negedge clk);
        idle();
    endtask

    initial begin
        rst_n = 0; idle(); cpu_super = 0; cpu_addr = '0; cfg_sel = 0; cfg_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        #1;
        chk("R1 fault", int'(fault), 0);
        @(negedge clk); cpu_super = 0; cpu_rd = 1; cpu_addr = 8'd0; #1;
        chk("R1 limit zero blocks", int'(bus_err), 1);
        @(negedge clk); idle(); #1;
        chk("R8 set after err", int'(fault), 1);
        @(negedge clk); #1;
        chk("R8 holds", int'(fault), 1);
        clr_fault(); #1;
        chk("R8 cleared", int'(fault), 0);

        // R6: program base=16, limit=100
        prog(1'b0, 16); prog(1'b1, 100);
        user_sweep("sweepA", 16, 100);
        clr_fault();
        prog(1'b0, 0); prog(1'b1, 255);
        user_sweep("sweepB", 0, 255);
        clr_fault();
        // R9: wrap
        prog(1'b0, 200); prog(1'b1, 128);
        user_sweep("sweepC_R9", 200, 128);
        clr_fault();

        // R5: supervisor sweep with restrictive limit
        prog(1'b1, 1);
        for (int a = 0; a < SPAN; a++) begin
            @(negedge clk);
            idle(); cpu_super = 1; cpu_addr = AW'(a); cpu_wr = 1; #1;
            chk("R5 addr", int'(mem_addr), a);
            chk("R5 no err", int'(bus_err), 0);
            chk("R5 strobe", int'(mem_wr), 1);
        end
        @(negedge clk); idle(); #1;
        chk("R5 no fault", int'(fault), 0);

        // R4: no strobe
        cpu_super = 0; cpu_addr = 8'd250; #1;
        chk("R4 idle no err", int'(bus_err), 0);
        chk("R4 idle no strobe", {mem_rd, mem_wr}, 0);

        // R7: user write ignored, flags fault
        @(negedge clk); idle(); cpu_super = 0; cfg_we = 1; cfg_sel = 1; cfg_data = 8'd250;
        @(negedge clk); idle(); #1;
        chk("R7 fault", int'(fault), 1);
        cpu_rd = 1; cpu_addr = 8'd5; #1;
        chk("R7 limit unchanged", int'(bus_err), 1);
        @(negedge clk); idle(); cfg_we = 1; cfg_sel = 0; cfg_data = 8'd77;
        @(negedge clk); idle(); prog(1'b1, 255); clr_fault();
        @(negedge clk); cpu_super = 0; cpu_rd = 1; cpu_addr = 8'd3; #1;
        chk("R7 base unchanged", int'(mem_addr), 3 + 200);

        // R8: violation and clear together -> stays set
        @(negedge clk); idle(); cpu_super = 0; cpu_wr = 1; cpu_addr = 8'd255; fault_clr = 1;
        @(negedge clk); idle(); #1;
        chk("R8 set wins", int'(fault), 1);
        clr_fault(); #1;
        chk("R8 clear", int'(fault), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule